// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host-side master for a three-wire serial analog-to-digital converter. On a start request it lowers chip select, waits out the converter's wake-up time, and then generates a mode-0 serial clock that idles low. It samples the data line on each rising clock edge and collects one 16-bit frame. The frame carries three leading ones, a channel identifier and a 12-bit result sent most significant bit first. The reader returns the result and the channel identifier with a one-cycle completion pulse.

Two read styles are supported, chosen per request. In the first, the serial clock drives the conversion itself. In the second, the converter runs on its own oscillator: the reader raises the clock before lowering chip select, gives one falling edge to start the conversion, and waits for the data line to go high before it clocks the frame out. A timeout bounds that wait. The serial clock half-period, the wake-up wait, the minimum chip-select high time and the timeout are all parameters counted in system clocks.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and after it is released, chip select is high, the serial clock is low, and busy and done are low.
- R2: For a clock-driven read (`int_mode`=0), chip select falls while the serial clock is low. The serial clock makes no transition until at least `WAKE_CYC` system clocks after chip select falls.
- R3: While chip select is low, every high phase of the serial clock lasts exactly `SCLK_HALF` system clocks. A completed frame has exactly 16 rising edges. The line is sampled on each rising edge, and the first bit sampled becomes frame bit 15.
- R4: In the frame, bits 15..13 are the leading ones, bit 12 is the channel identifier (`chan_id`), and bits 11..0 are the result, most significant bit first.
- R5: If any of frame bits 15..13 reads as zero, `frame_err` is set with the done pulse. The result and the channel identifier are still updated.
- R6: Chip select rises on the same system clock as the 16th falling edge of the serial clock. `done` pulses for exactly one cycle on that clock, with chip select high, the serial clock low, and the outputs valid.
- R7: `busy` is high from an accepted start until `CS_HIGH_CYC` clocks after chip select rises. Chip select stays high at least `CS_HIGH_CYC` clocks between reads. A start request while busy has no effect.
- R8: For a self-clocked read (`int_mode`=1), the serial clock is raised `SCLK_HALF` clocks before chip select falls and is held high through the wake-up wait. A single falling edge follows. The reader then waits for the data line to go high before it clocks out a 16-bit frame as in R3.
- R9: If the data line stays low for `EOC_TIMEOUT` clocks in a self-clocked read, chip select is raised and `done` pulses with `timeout_err` set. The result and the channel identifier keep their previous values.
- R10: `frame_err` and `timeout_err` are rewritten with every done pulse, and they are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one read (ignored while busy) |
| int_mode | input | 1 | Read style, sampled with start: 1 = converter self-clocked |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Read or chip-select recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Conversion result |
| chan_id | output | 1 | Channel identifier from the frame |
| frame_err | output | 1 | A leading bit was zero |
| timeout_err | output | 1 | End of conversion did not appear in time |

## Verification
The results appear on the clock edge that raises chip select, and that edge is itself the 16th serial falling edge. So a clock-driven read completes `WAKE_CYC + 32*SCLK_HALF` clocks after chip select falls, and a self-clocked read completes a data-dependent delay later. The scoreboard therefore does not wait a fixed count. It queues each expected item when the request is issued and compares it on the negative clock edge where `done` is seen high. The timing rules are measured by counting system clocks between edges observed at the ports: the wake-up gap, each high-phase width, the rising edges per frame and the chip-select high gap. Each count is checked against its parameter on the half-cycle after the edge that ends it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    parameter int LEAD_ONES = 3;
    parameter int RES_W     = 12;
    parameter int FRAME_W   = LEAD_ONES + 1 + RES_W;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_PRE,
        RD_WAKE,
        RD_EOC,
        RD_LO,
        RD_HI,
        RD_HOLD
    } rd_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_frame.sv
module adc_rd_frame #(
    parameter int LEAD = adc_rd_pkg::LEAD_ONES,
    parameter int RES  = adc_rd_pkg::RES_W,
    localparam int FW  = LEAD + 1 + RES
) (
    input  logic [FW-1:0]  frame,
    output logic [RES-1:0] res,
    output logic           chid,
    output logic           lead_ok
);
    logic [LEAD:0] chain;
    assign chain[0] = 1'b1;

    // AND chain over the leading marker bits, first-sent bit at the top
    for (genvar g = 0; g < LEAD; g++) begin : g_lead
        assign chain[g+1] = chain[g] & frame[FW-1-g];
    end

    assign lead_ok = chain[LEAD];
    assign chid    = frame[RES];
    assign res     = frame[RES-1:0];
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int SCLK_HALF   = 2,
    parameter int WAKE_CYC    = 10,
    parameter int CS_HIGH_CYC = 4,
    parameter int EOC_TIMEOUT = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             int_mode,
    input  logic             miso,
    output logic             sclk,
    output logic             cs_n,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             chan_id,
    output logic             frame_err,
    output logic             timeout_err
);
    localparam int FW   = FRAME_W;
    localparam int NBW  = $clog2(FW + 1);
    localparam int MAXV = max2(max2(SCLK_HALF, WAKE_CYC), max2(CS_HIGH_CYC, EOC_TIMEOUT));
    localparam int CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0]  LD_HALF = CW'(SCLK_HALF - 1);
    localparam logic [CW-1:0]  LD_WAKE = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0]  LD_HOLD = CW'(CS_HIGH_CYC - 1);
    localparam logic [CW-1:0]  LD_EOC  = CW'(EOC_TIMEOUT - 1);
    localparam logic [NBW-1:0] LAST    = NBW'(FW);

    typedef struct packed {
        rd_state_e        st;
        logic [NBW-1:0]   nbit;
        logic             sclk;
        logic             cs_n;
        logic             mode;
        logic [FW-1:0]    sh;
        logic             done;
        logic [RES_W-1:0] res;
        logic             chid;
        logic             ferr;
        logic             terr;
    } rd_regs_t;

    rd_regs_t         r_d, r_q;
    logic             tm_load;
    logic [CW-1:0]    tm_val;
    logic             tm_zero;
    logic [RES_W-1:0] dec_res;
    logic             dec_chid;
    logic             dec_ok;
    logic             rd_mode;

    adc_rd_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_zero)
    );

    adc_rd_frame #(.LEAD(LEAD_ONES), .RES(RES_W)) u_frame (
        .frame   (r_q.sh),
        .res     (dec_res),
        .chid    (dec_chid),
        .lead_ok (dec_ok)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tm_load  = 1'b0;
        tm_val   = '0;
        unique case (r_q.st)
            RD_IDLE: begin
                if (start) begin
                    r_d.mode = int_mode;
                    r_d.nbit = '0;
                    tm_load  = 1'b1;
                    if (int_mode) begin
                        r_d.sclk = 1'b1;
                        r_d.st   = RD_PRE;
                        tm_val   = LD_HALF;
                    end else begin
                        r_d.cs_n = 1'b0;
                        r_d.st   = RD_WAKE;
                        tm_val   = LD_WAKE;
                    end
                end
            end
            RD_PRE: begin
                if (tm_zero) begin
                    r_d.cs_n = 1'b0;
                    r_d.st   = RD_WAKE;
                    tm_load  = 1'b1;
                    tm_val   = LD_WAKE;
                end
            end
            RD_WAKE: begin
                if (tm_zero) begin
                    tm_load = 1'b1;
                    if (r_q.mode) begin
                        r_d.sclk = 1'b0;
                        r_d.st   = RD_EOC;
                        tm_val   = LD_EOC;
                    end else begin
                        r_d.st   = RD_LO;
                        tm_val   = LD_HALF;
                    end
                end
            end
            RD_EOC: begin
                if (miso) begin
                    r_d.st  = RD_LO;
                    tm_load = 1'b1;
                    tm_val  = LD_HALF;
                end else if (tm_zero) begin
                    r_d.cs_n = 1'b1;
                    r_d.done = 1'b1;
                    r_d.terr = 1'b1;
                    r_d.ferr = 1'b0;
                    r_d.st   = RD_HOLD;
                    tm_load  = 1'b1;
                    tm_val   = LD_HOLD;
                end
            end
            RD_LO: begin
                if (tm_zero) begin
                    r_d.sclk = 1'b1;
                    r_d.sh   = {r_q.sh[FW-2:0], miso};
                    r_d.nbit = r_q.nbit + 1'b1;
                    r_d.st   = RD_HI;
                    tm_load  = 1'b1;
                    tm_val   = LD_HALF;
                end
            end
            RD_HI: begin
                if (tm_zero) begin
                    r_d.sclk = 1'b0;
                    tm_load  = 1'b1;
                    if (r_q.nbit == LAST) begin
                        r_d.cs_n = 1'b1;
                        r_d.done = 1'b1;
                        r_d.res  = dec_res;
                        r_d.chid = dec_chid;
                        r_d.ferr = ~dec_ok;
                        r_d.terr = 1'b0;
                        r_d.st   = RD_HOLD;
                        tm_val   = LD_HOLD;
                    end else begin
                        r_d.st   = RD_LO;
                        tm_val   = LD_HALF;
                    end
                end
            end
            RD_HOLD: begin
                if (tm_zero) r_d.st = RD_IDLE;
            end
            default: r_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= RD_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk        = r_q.sclk;
    assign cs_n        = r_q.cs_n;
    assign busy        = (r_q.st != RD_IDLE);
    assign done        = r_q.done;
    assign result      = r_q.res;
    assign chan_id     = r_q.chid;
    assign frame_err   = r_q.ferr;
    assign timeout_err = r_q.terr;
    assign rd_mode     = r_q.mode;
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int WAKE_CYC    = 10,
    parameter int CS_HIGH_CYC = 4,
    parameter int RW          = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclk,
    input logic          cs_n,
    input logic          busy,
    input logic          done,
    input logic [RW-1:0] result,
    input logic          frame_err,
    input logic          timeout_err,
    input logic          rd_mode
);
    localparam int WCW = $clog2(WAKE_CYC + 1);
    localparam int HCW = $clog2(CS_HIGH_CYC + 1);
    localparam logic [WCW-1:0] WSAT = WCW'(WAKE_CYC);
    localparam logic [HCW-1:0] HSAT = HCW'(CS_HIGH_CYC);

    logic [WCW-1:0] low_cnt;
    logic [HCW-1:0] high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= HSAT;
        end else begin
            low_cnt  <= cs_n ? '0 : ((low_cnt == WSAT) ? low_cnt : low_cnt + 1'b1);
            high_cnt <= !cs_n ? '0 : ((high_cnt == HSAT) ? high_cnt : high_cnt + 1'b1);
        end
    end

    // R2
    wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $rose(sclk)) |-> (low_cnt >= WSAT));
    // R8
    cs_fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (sclk == rd_mode));
    // R6
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(cs_n) && !sclk));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
    // R7
    cs_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (high_cnt >= HSAT));
    // R9
    timeout_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout_err) |-> $stable(result));
    // R10
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && timeout_err));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
    .WAKE_CYC    (WAKE_CYC),
    .CS_HIGH_CYC (CS_HIGH_CYC),
    .RW          (adc_rd_pkg::RES_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .frame_err   (frame_err),
    .timeout_err (timeout_err),
    .rd_mode     (rd_mode)
);

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
    localparam int CLK_PERIOD  = 10;
    localparam int SCLK_HALF   = 2;
    localparam int WAKE_CYC    = 10;
    localparam int CS_HIGH_CYC = 4;
    localparam int EOC_TIMEOUT = 50;
    localparam int WD_CYCLES   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic int_mode = 1'b0;
    logic miso_m = 1'b0;
    logic sclk, cs_n, busy, done, chan_id, frame_err, timeout_err;
    logic [11:0] result;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_frame_reader #(
        .SCLK_HALF(SCLK_HALF), .WAKE_CYC(WAKE_CYC),
        .CS_HIGH_CYC(CS_HIGH_CYC), .EOC_TIMEOUT(EOC_TIMEOUT)
    ) i_adc_frame_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .int_mode(int_mode),
        .miso(miso_m), .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done),
        .result(result), .chan_id(chan_id), .frame_err(frame_err),
        .timeout_err(timeout_err)
    );

    int n_tot = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    endtask

    // ---------------- converter model ----------------
    logic [15:0] m_frame = '0;
    int  m_dly = 0;
    bit  m_int = 0;
    bit  m_conv = 0;
    int  m_idx = 0;

    always @(negedge cs_n) begin
        m_int  = sclk;
        m_conv = 0;
        m_idx  = 0;
        miso_m = sclk ? 1'b0 : m_frame[15];
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (m_int && !m_conv) begin
                m_conv = 1;
                if (m_dly >= 0) begin
                    fork
                        begin
                            repeat (m_dly) @(negedge clk);
                            miso_m = m_frame[15];
                        end
                    join_none
                end
            end else begin
                m_idx++;
                miso_m = (m_idx < 16) ? m_frame[15 - m_idx] : 1'b0;
            end
        end
    end

    always @(posedge cs_n) miso_m = 1'b0;

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [11:0] res;
        logic        chid;
        logic        ferr;
        logic        terr;
    } exp_t;
    exp_t exp_q[$];
    logic [11:0] last_res = '0;
    logic        last_chid = 1'b0;
    bit          cur_mode = 0;
    int          exp_rises = 16;

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(result == e.res, "R4", "result", result, e.res);
                chk(chan_id == e.chid, "R4", "chan_id", chan_id, e.chid);
                chk(frame_err == e.ferr, "R5", "frame_err", frame_err, e.ferr);
                chk(timeout_err == e.terr, "R9", "timeout_err", timeout_err, e.terr);
            end
            chk(cs_n && !sclk, "R6", "cs_n/sclk at done", {cs_n, sclk}, 2'b10);
        end
    end

    // ---------------- edge timing monitor ----------------
    longint cyc = 0;
    logic   p_cs = 1'b1, p_sclk = 1'b0, p_done = 1'b0;
    longint fall_cyc = 0, hi_cyc = 0, rise_cyc = -1;
    bit     first_edge = 0, hi_valid = 0;
    int     rises = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_done) chk(!done, "R6", "done width", done, 0);
            if (p_sclk && !sclk && hi_valid) begin
                chk(cyc - hi_cyc == SCLK_HALF, "R3", "high phase", cyc - hi_cyc, SCLK_HALF);
                hi_valid = 0;
            end
            if (!cs_n && (sclk != p_sclk) && first_edge && !p_cs == 1'b1) begin
                chk(cyc - fall_cyc >= WAKE_CYC, "R2", "wake gap", cyc - fall_cyc, WAKE_CYC);
                first_edge = 0;
            end
            if (!cs_n && !p_sclk && sclk) begin
                rises++;
                hi_cyc = cyc;
                hi_valid = 1;
            end
            if (p_cs && !cs_n) begin
                if (cur_mode) chk(sclk == 1'b1, "R8", "sclk level at cs fall", sclk, 1);
                else          chk(sclk == 1'b0, "R2", "sclk level at cs fall", sclk, 0);
                if (rise_cyc >= 0)
                    chk(cyc - rise_cyc >= CS_HIGH_CYC, "R7", "cs high gap", cyc - rise_cyc, CS_HIGH_CYC);
                fall_cyc = cyc;
                first_edge = 1;
                rises = 0;
            end
            if (!p_cs && cs_n) begin
                chk(rises == exp_rises, "R3", "rising edges", rises, exp_rises);
                rise_cyc = cyc;
            end
        end
        p_cs = cs_n;
        p_sclk = sclk;
        p_done = done;
    end

    // ---------------- driver ----------------
    task automatic do_read(input bit im, input logic [15:0] fr, input int dly, input bit again);
        exp_t e;
        while (busy) @(negedge clk);
        m_frame   = fr;
        m_dly     = dly;
        cur_mode  = im;
        exp_rises = (im && dly < 0) ? 0 : 16;
        if (im && dly < 0) begin
            e.res = last_res; e.chid = last_chid; e.ferr = 1'b0; e.terr = 1'b1;
        end else begin
            e.res = fr[11:0]; e.chid = fr[12]; e.ferr = (fr[15:13] != 3'b111); e.terr = 1'b0;
            last_res = fr[11:0]; last_chid = fr[12];
        end
        exp_q.push_back(e);
        int_mode = im;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (again) begin
            repeat (30) @(negedge clk);
            int_mode = ~im;
            start = 1'b1;   // R7: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs_n/sclk in reset", {cs_n, sclk}, 2'b10);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && !busy, "R1", "idle after reset",
            {cs_n, sclk, busy}, 3'b100);

        do_read(0, 16'hEABC, 0, 0);    // R4 chid 0
        do_read(0, 16'hF123, 0, 0);    // R4 chid 1
        do_read(0, 16'hFFFF, 0, 0);    // R3 all ones
        do_read(0, 16'hE000, 0, 0);    // R3 all zeros in result
        do_read(1, 16'hF5A5, 20, 0);   // R8 self-clocked
        do_read(0, 16'h6456, 0, 0);    // R5 bad leading bit
        do_read(1, 16'hE111, -1, 0);   // R9 timeout, R10
        do_read(0, 16'hE7E7, 0, 1);    // R7 start while busy
        do_read(1, 16'hE00F, 0, 0);    // R8 immediate end of conversion
        do_read(0, 16'hB3C3, 0, 0);    // R5 middle leading bit zero

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "pending results", exp_q.size(), 0);
        chk(!busy && cs_n, "R7", "idle at end", {busy, cs_n}, 2'b01);
        summary();
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_tot++;
        n_fail++;
        $display("FAIL R7 watchdog: busy=%0h exp=0", busy);
        summary();
        $finish;
    end
endmodule